// File: doc/BRIEF.md
# Transmit-Empty Interrupt Source with Startup Holdoff

This block decides when a UART transmitter with a FIFO raises its "transmit FIFO empty" interrupt. It watches the FIFO occupancy, the write strobe into the transmit FIFO and the strobe that reads the interrupt-identification register. From these it keeps one pending flag and the 3-bit identification code that this source reports.

If the FIFO has held two or more characters at one time since the last empty event, the interrupt is raised as soon as the FIFO is seen empty. If it has not, the interrupt waits one character time minus the stop bit. That wait is counted in 16x baud ticks. Software that is filling the FIFO at start-up therefore gets time to refill it before the interrupt arrives. A write during the wait cancels it. Arbitration against other interrupt sources is done outside the block: the block only receives a flag saying whether it is the highest-priority source being reported.

The control is a four-state machine:
- `ST_ARMED`: the FIFO holds data, or the block is waiting to see it empty.
- `ST_HOLDOFF`: the FIFO is empty and the delay is running.
- `ST_PENDING`: the interrupt is asserted.
- `ST_SERVED`: the interrupt was cleared by an identification read while the FIFO stays empty.

The transitions are:
- ARMED→PENDING: the FIFO is empty, no write is present and the two-character flag is set.
- ARMED→HOLDOFF: the same condition with the flag clear.
- HOLDOFF→PENDING: the tick that completes the delay.
- HOLDOFF→ARMED: a write, or the FIFO is no longer empty.
- PENDING→ARMED: a write.
- PENDING→SERVED: an identification read while this source is top priority.
- SERVED→ARMED: a write, or the FIFO is no longer empty.

Top module: `txempty_irq`

## Requirements
- R1: `irq_code` is 3'b001 while `irq_pend` is high and 3'b000 otherwise.
- R2: A synchronous active-high reset clears the pending flag, the two-character flag and the delay counter. After reset, an empty FIFO goes through the full delay.
- R3: The FIFO may be seen empty (`tx_level` = 0 with no `tx_push`) at a clock edge when it has not held two or more characters since the last empty event. In that case `irq_pend` rises at the edge that samples the Nth tick after that edge, where N = 16 × (1 + data bits + parity bit). Data bits are 5 + `word_len` (`word_len` 0..3 selects 5..8 bits). The parity bit counts 1 when `parity_on` is 1.
- R4: If the FIFO has held two or more characters at once since the last empty event, `irq_pend` rises at the same edge that first sees the FIFO empty.
- R5: A `tx_push` clears `irq_pend` at the next edge.
- R6: An `id_read` clears `irq_pend` only when `src_is_top` is 1. Once cleared this way, the interrupt stays low while the FIFO stays empty and no write occurs.
- R7: Only cycles with `baud_x16` high advance the delay. Cycles without it leave the remaining delay unchanged.
- R8: A `tx_push` during the delay cancels it, and no interrupt is raised until a later empty event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | CNT_W | Transmit FIFO occupancy count |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| id_read | input | 1 | Interrupt-identification register read strobe |
| src_is_top | input | 1 | This source is the highest pending interrupt |
| baud_x16 | input | 1 | 16x baud tick |
| word_len | input | 2 | Data bits minus 5 |
| parity_on | input | 1 | Frame carries a parity bit |
| irq_pend | output | 1 | Interrupt pending |
| irq_code | output | 3 | Identification code of this source |

## Verification
The assertions check on every cycle the behaviours that are local in time:
- a write, or a qualifying identification read, drops the pending flag at the next edge;
- a read while another source is on top leaves the flag up;
- an empty FIFO with the two-character flag set raises the interrupt at once;
- the delay counter holds its value on cycles without a tick;
- every rise of the interrupt is caused either by the two-character flag or by the end of the delay.

Only the bench scenarios can show the full length of the delay for each frame format, and that a cancelled delay stays silent for longer than a frame. They also show that a fresh empty event restarts the count from zero. Random traffic compared against a bench model covers the interleavings of writes, drains and reads.

// File: rtl/txempty_irq_pkg.sv
package txempty_irq_pkg;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_HOLDOFF = 2'd1,
        ST_PENDING = 2'd2,
        ST_SERVED  = 2'd3
    } txe_state_t;

    localparam logic [2:0] TXE_CODE  = 3'b001;
    localparam logic [2:0] NONE_CODE = 3'b000;

    localparam int MIN_DATA_BITS = 5;
    localparam int MAX_DATA_BITS = 8;

endpackage

// File: rtl/txempty_fill_track.sv
module txempty_fill_track #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             empty_evt,
    output logic             multi_seen
);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic multi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            multi_q <= 1'b0;
        end else if (empty_evt) begin
            multi_q <= 1'b0;
        end else if (tx_level >= TWO) begin
            multi_q <= 1'b1;
        end
    end

    assign multi_seen = multi_q;

    // R4: a level of two or more is remembered until the next empty event
    assert_multi_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_level >= TWO && !empty_evt) |=> multi_seen);

endmodule

// File: rtl/txempty_holdoff.sv
module txempty_holdoff #(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_run,
    input  logic       baud_x16,
    input  logic [1:0] word_len,
    input  logic       parity_on,
    output logic       expire
);
    import txempty_irq_pkg::*;

    localparam int BASE_BITS = 1 + MIN_DATA_BITS;
    localparam int TERM_MAX  = OVERSAMPLE * (1 + MAX_DATA_BITS + 1);
    localparam int HC_W      = $clog2(TERM_MAX + 1);

    logic [HC_W-1:0] hold_cnt;
    logic [HC_W-1:0] term;

    assign term = HC_W'(OVERSAMPLE) *
                  (HC_W'(BASE_BITS) + HC_W'(word_len) + HC_W'(parity_on));

    always_ff @(posedge clk) begin
        if (rst || !hold_run) begin
            hold_cnt <= '0;
        end else if (baud_x16) begin
            hold_cnt <= hold_cnt + HC_W'(1);
        end
    end

    assign expire = hold_run && baud_x16 && (hold_cnt + HC_W'(1) >= term);

    // R7: cycles without a tick leave the delay where it was
    assert_tick_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (hold_run && !baud_x16) |=> $stable(hold_cnt));

endmodule

// File: rtl/txempty_fsm.sv
module txempty_fsm (
    input  logic       clk,
    input  logic       rst,
    input  logic       level_zero,
    input  logic       tx_push,
    input  logic       id_read,
    input  logic       src_is_top,
    input  logic       multi_seen,
    input  logic       expire,
    output logic       empty_evt,
    output logic       hold_run,
    output logic       irq_pend,
    output logic [2:0] irq_code
);
    import txempty_irq_pkg::*;

    txe_state_t state_q;
    txe_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (level_zero && !tx_push) begin
                    state_d = multi_seen ? ST_PENDING : ST_HOLDOFF;
                end
            end
            ST_HOLDOFF: begin
                if (tx_push || !level_zero) begin
                    state_d = ST_ARMED;
                end else if (expire) begin
                    state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                if (tx_push) begin
                    state_d = ST_ARMED;
                end else if (id_read && src_is_top) begin
                    state_d = ST_SERVED;
                end
            end
            ST_SERVED: begin
                if (tx_push || !level_zero) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        empty_evt = (state_q == ST_ARMED) && level_zero && !tx_push;
        hold_run  = (state_q == ST_HOLDOFF);
        irq_pend  = (state_q == ST_PENDING);
        irq_code  = irq_pend ? TXE_CODE : NONE_CODE;
    end

    // R5: a write drops a pending interrupt at the next edge
    assert_push_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && tx_push) |=> !irq_pend);

    // R6: an identification read clears only when this source is on top
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && id_read && src_is_top) |=> !irq_pend);

    assert_read_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && id_read && !src_is_top && !tx_push) |=> irq_pend);

    // R4: an empty event after two or more characters raises at once
    assert_immediate_R4: assert property (@(posedge clk) disable iff (rst)
        (empty_evt && multi_seen) |=> irq_pend);

    // R8: a write during the delay never lets the interrupt rise
    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (hold_run && tx_push) |=> !irq_pend);

    // R3: every rise comes from the two-character flag or the end of the delay
    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend) |-> ($past(multi_seen) || $past(expire)));

endmodule

// File: rtl/txempty_irq.sv
module txempty_irq #(
    parameter int FIFO_DEPTH = 16,
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             tx_push,
    input  logic             id_read,
    input  logic             src_is_top,
    input  logic             baud_x16,
    input  logic [1:0]       word_len,
    input  logic             parity_on,
    output logic             irq_pend,
    output logic [2:0]       irq_code
);
    logic level_zero;
    logic empty_evt;
    logic hold_run;
    logic multi_seen;
    logic expire;

    assign level_zero = (tx_level == '0);

    txempty_fill_track #(
        .CNT_W (CNT_W)
    ) track_i (
        .clk        (clk),
        .rst        (rst),
        .tx_level   (tx_level),
        .empty_evt  (empty_evt),
        .multi_seen (multi_seen)
    );

    txempty_holdoff #(
        .OVERSAMPLE (OVERSAMPLE)
    ) hold_i (
        .clk       (clk),
        .rst       (rst),
        .hold_run  (hold_run),
        .baud_x16  (baud_x16),
        .word_len  (word_len),
        .parity_on (parity_on),
        .expire    (expire)
    );

    txempty_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .level_zero (level_zero),
        .tx_push    (tx_push),
        .id_read    (id_read),
        .src_is_top (src_is_top),
        .multi_seen (multi_seen),
        .expire     (expire),
        .empty_evt  (empty_evt),
        .hold_run   (hold_run),
        .irq_pend   (irq_pend),
        .irq_code   (irq_code)
    );

endmodule

// File: tb/txempty_irq_tb_top.sv
`timescale 1ns/1ps
module txempty_irq_tb_top;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] tx_level = '0;
    logic          tx_push = 1'b0;
    logic          id_read = 1'b0;
    logic          src_is_top = 1'b0;
    logic          baud_x16 = 1'b0;
    logic [1:0]    word_len = 2'd3;
    logic          parity_on = 1'b0;
    logic          irq_pend;
    logic [2:0]    irq_code;

    int  total = 0;
    int  bad = 0;
    bit  p_wr = 0;
    bit  p_pop = 0;

    always #2.5 clk = ~clk;

    txempty_irq #(.FIFO_DEPTH(DEPTH), .OVERSAMPLE(16)) dut_i (
        .clk(clk), .rst(rst), .tx_level(tx_level), .tx_push(tx_push),
        .id_read(id_read), .src_is_top(src_is_top), .baud_x16(baud_x16),
        .word_len(word_len), .parity_on(parity_on),
        .irq_pend(irq_pend), .irq_code(irq_code)
    );

    function automatic int frame_ticks(input logic [1:0] wl, input logic par);
        return 16 * (1 + 5 + int'(wl) + int'(par));
    endfunction

    function automatic logic [2:0] code_for(input bit pend);
        return pend ? 3'b001 : 3'b000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: apply last cycle's FIFO effect, drive inputs, wait past the edge
    task automatic cyc(input bit r, input bit wr, input bit pop, input bit rd,
                       input bit top, input bit tk);
        bit w;
        bit p;
        @(negedge clk);
        if (p_wr && !p_pop) tx_level = tx_level + 1'b1;
        else if (!p_wr && p_pop) tx_level = tx_level - 1'b1;
        w = wr && (tx_level != CW'(DEPTH));
        p = pop && (tx_level != '0);
        rst = r;
        tx_push = w;
        id_read = rd;
        src_is_top = top;
        baud_x16 = tk;
        p_wr = w && !r;
        p_pop = p && !r;
        @(posedge clk);
        #1;
    endtask

    // bench model of the interrupt source
    bit m_pend = 0, m_multi = 0, m_hold = 0, m_armed = 1, m_evt = 0;
    int m_ticks = 0;
    always @(posedge clk) begin
        m_evt = 0;
        if (rst) begin
            m_pend = 0; m_multi = 0; m_hold = 0; m_armed = 1; m_ticks = 0;
        end else begin
            if (m_armed) begin
                if (tx_level == '0 && !tx_push) begin
                    m_evt = 1;
                    m_armed = 0;
                    if (m_multi) m_pend = 1;
                    else begin m_hold = 1; m_ticks = 0; end
                end
            end else if (m_hold) begin
                if (tx_push || tx_level != '0) begin
                    m_hold = 0; m_armed = 1;
                end else if (baud_x16) begin
                    m_ticks++;
                    if (m_ticks >= frame_ticks(word_len, parity_on)) begin
                        m_hold = 0; m_pend = 1;
                    end
                end
            end else if (m_pend) begin
                if (tx_push) begin m_pend = 0; m_armed = 1; end
                else if (id_read && src_is_top) m_pend = 0;
            end else if (tx_push || tx_level != '0) begin
                m_armed = 1;
            end
            if (m_evt) m_multi = 0;
            else if (tx_level >= CW'(2)) m_multi = 1;
        end
    end

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));

        // R2: reset state
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
        check("R2 reset pend", irq_pend, 0);
        check("R1 reset code", irq_code, 3'b000);

        // R3: startup delay, 8 data bits, no parity
        n = frame_ticks(2'd3, 1'b0);
        cyc(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < n - 1; i++) cyc(0, 0, 0, 0, 0, 1);
        check("R3 startup held off", irq_pend, 0);
        cyc(0, 0, 0, 0, 0, 1);
        check("R3 startup raised", irq_pend, 1);
        check("R1 pend code", irq_code, 3'b001);

        // R6: read when not top keeps, when top clears, stays quiet
        cyc(0, 0, 0, 1, 0, 1);
        check("R6 read not top", irq_pend, 1);
        cyc(0, 0, 0, 1, 1, 1);
        check("R6 read top", irq_pend, 0);
        for (int i = 0; i < 200; i++) cyc(0, 0, 0, 0, 0, 1);
        check("R6 stays served", irq_pend, 0);

        // R8: write during the delay cancels it
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 50; i++) cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 300; i++) cyc(0, 0, 0, 0, 0, 1);
        check("R8 aborted silent", irq_pend, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < n - 1; i++) cyc(0, 0, 0, 0, 0, 1);
        check("R8 new delay counts from zero", irq_pend, 0);
        cyc(0, 0, 0, 0, 0, 1);
        check("R8 new delay ends", irq_pend, 1);

        // R5: write clears
        cyc(0, 1, 0, 0, 0, 0);
        check("R5 write clears", irq_pend, 0);
        check("R1 cleared code", irq_code, 3'b000);

        // R4: two characters held then drained raises at once
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        check("R4 before empty", irq_pend, 0);
        cyc(0, 0, 0, 0, 0, 0);
        check("R4 immediate", irq_pend, 1);
        cyc(0, 1, 0, 0, 0, 0);
        check("R5 write clears again", irq_pend, 0);

        // R7 and R3: 6 data bits with parity, tick every other cycle
        word_len = 2'd1;
        parity_on = 1'b1;
        n = frame_ticks(2'd1, 1'b1);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < n - 1; i++) begin
            cyc(0, 0, 0, 0, 0, 1);
            cyc(0, 0, 0, 0, 0, 0);
        end
        check("R3 parity frame held off", irq_pend, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0);
        check("R7 no tick no advance", irq_pend, 0);
        cyc(0, 0, 0, 0, 0, 1);
        check("R7 last tick raises", irq_pend, 1);

        // random traffic against the bench model (R1 R3 R4 R5 R6 R8)
        for (int blk = 0; blk < 12; blk++) begin
            int wr_div;
            wr_div = (blk % 3 == 0) ? 4 : ((blk % 3 == 1) ? 40 : 400);
            word_len = 2'($urandom_range(0, 3));
            parity_on = 1'($urandom_range(0, 1));
            cyc(1, 0, 0, 0, 0, 0);
            for (int i = 0; i < 500; i++) begin
                cyc(0, $urandom_range(0, wr_div - 1) == 0,
                       $urandom_range(0, 4) == 0,
                       $urandom_range(0, 7) == 0,
                       $urandom_range(0, 1) == 1,
                       $urandom_range(0, 1) == 1);
                check("R5 random pend", irq_pend, m_pend);
                check("R1 random code", irq_code, code_for(m_pend));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule